// File: doc/BRIEF.md
# DMA Global Control and Interrupt Register Block

This block is the shared register front end of a multi-channel DMA engine. It sits on a simple 32-bit register bus. Each cycle it decodes one access and takes one of three paths. Addresses in the low region go to per-channel register windows through a one-hot channel select and a word index. Addresses in the global region reach a small set of shared registers. All other addresses read as zero and ignore writes.

The shared registers hold the following:
- A global enable and a fast-mode option bit.
- A per-channel doorbell that asks a channel to fetch its next descriptor. A channel clears its doorbell by acknowledging it.
- Per-channel completion-pending bits, which are combined into one interrupt line.
- Two sticky summary flags that record any channel halt or address error.
- A channel-programmable mask and four words of interrupt pending and mask storage.

Software clears the pending bits and the summary flags by writing zeros over them. Writing ones never sets them. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `dma_glob_regs`

## Requirements
- R1: After reset, every global register reads zero, and `fetchReq`, `irq`, `progMask` and `chSel` are all zero.
- R2: The control word at 0x1000 stores the enable in bit 0 and the fast-mode option in bit 31. Both are readable and writable. Bits 1 and 4 to 30 read zero. The `globalEn` and `fastMode` outputs follow the stored bits.
- R3: Control bit 3 (halt summary) is set by any `chHalt` pulse. Control bit 2 (address-error summary) is set by any `chAddrErr` pulse. Each stays set until a control write carries a 0 in that bit position. A control write carrying a 1 there does not set it. Clearing one flag leaves the other flag and the enable unchanged.
- R4: A write to 0x100C sets doorbell bit n for every 1 in bit n of the write data, and only while the enable is 1. Zero bits have no effect. Writes made while the enable is 0 have no effect. The doorbell reads at 0x1008 and drives `fetchReq`. Writes to 0x1008 are ignored. 0x100C reads zero.
- R5: A `fetchAck[n]` pulse clears doorbell bit n at the next edge. If a doorbell-set write for the same bit happens in the same cycle, the bit stays set.
- R6: The pending word at 0x1004 sets bit n on a `chDone[n]` pulse. A write keeps only the bits that were written as 1. A completion arriving in the same cycle as a clearing write still sets its bit.
- R7: `irq` is 1 exactly when the enable is 1 and at least one pending bit is 1.
- R8: An access with `busSel` high and an address below 0x400 asserts `chSel[n]` for n = address bits 9:5. `chWordSel` carries address bits 4:2. A read returns `chRdata`. `chSel` is all zero when `busSel` is low or the address is outside the window.
- R9: The words at 0x101C, 0x1020, 0x1024, 0x1028 and 0x102C are plain 32-bit read/write storage. The word at 0x101C drives `progMask`.
- R10: Reads of any other address return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 13 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| chSel | output | 32 | One-hot channel window select |
| chWordSel | output | 3 | Word index inside the channel window |
| chRdata | input | 32 | Read data from the selected channel |
| fetchReq | output | 32 | Doorbell bits, one per channel |
| fetchAck | input | 32 | Channel accepted its descriptor fetch |
| chDone | input | 32 | Channel completion pulses |
| chHalt | input | 32 | Channel halt pulses |
| chAddrErr | input | 32 | Channel address-error pulses |
| globalEn | output | 1 | Stored global enable |
| fastMode | output | 1 | Stored fast-mode option |
| progMask | output | 32 | Channel-programmable mask |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets collisions and gating. It applies a doorbell set and an acknowledge for the same channel in one cycle; a design that lets the acknowledge win would drop a fresh request. It applies a completion and a clearing write to the pending word in one cycle; a design that lets the write win would lose an interrupt. It rings a doorbell while the enable is off, and it writes ones into the summary flags; a block that skipped these guards would start a fetch or report a fault that never happened. It also probes the gaps between the mapped words and the space between the channel windows and the global region, where a loose decoder would alias onto a real register.

// File: rtl/dma_glob_pkg.sv
package dma_glob_pkg;

  // number of plain storage words in the global region
  localparam int AUX_N = 5;

  // word indices inside the global region
  localparam logic [3:0] W_CTRL    = 4'd0;
  localparam logic [3:0] W_PEND    = 4'd1;
  localparam logic [3:0] W_BELL    = 4'd2;
  localparam logic [3:0] W_BELLSET = 4'd3;
  localparam logic [3:0] W_PROG    = 4'd7;
  localparam logic [3:0] W_SOFTP   = 4'd8;
  localparam logic [3:0] W_SOFTM   = 4'd9;
  localparam logic [3:0] W_DESCP   = 4'd10;
  localparam logic [3:0] W_DESCM   = 4'd11;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_PEND,
    RD_BELL,
    RD_AUX,
    RD_CHAN
  } rdSel_e;

  typedef struct packed {
    logic             wrCtrl;
    logic             wrPend;
    logic             wrBellSet;
    logic [AUX_N-1:0] wrAux;
    rdSel_e           rdSel;
    logic [2:0]       auxIdx;
  } regStrobes_t;

endpackage

// File: rtl/dma_glob_decode.sv
module dma_glob_decode
  import dma_glob_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int NUM_CH       = 32,
  parameter int CH_WIN_BYTES = 32,
  parameter int GLOB_BASE    = 'h1000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busSel,
  input  logic                         busWrite,
  input  logic [ADDR_W-1:0]            busAddr,
  output regStrobes_t                  st,
  output logic [NUM_CH-1:0]            chSel,
  output logic [$clog2(CH_WIN_BYTES)-3:0] chWordSel
);

  localparam int WIN_SH   = $clog2(CH_WIN_BYTES);
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int WORD_W   = WIN_SH - 2;
  localparam logic [ADDR_W-1:0] CH_SPAN  = ADDR_W'(NUM_CH * CH_WIN_BYTES);
  localparam logic [ADDR_W-1:0] G_START  = ADDR_W'(GLOB_BASE);
  localparam logic [ADDR_W-1:0] G_END    = ADDR_W'(GLOB_BASE + 64);

  logic [ADDR_W-1:0] globOff;
  logic [3:0]        globWord;

  assign globOff  = busAddr - G_START;
  assign globWord = 4'(globOff >> 2);

  always_comb begin
    st        = '0;
    st.rdSel  = RD_NONE;
    chSel     = '0;
    chWordSel = busAddr[2 +: WORD_W];
    if (busSel) begin
      if (busAddr < CH_SPAN) begin
        chSel[busAddr[WIN_SH +: CH_IDX_W]] = 1'b1;
        st.rdSel = RD_CHAN;
      end else if (busAddr >= G_START && busAddr < G_END) begin
        unique case (globWord)
          W_CTRL:    begin st.rdSel = RD_CTRL; st.wrCtrl = busWrite; end
          W_PEND:    begin st.rdSel = RD_PEND; st.wrPend = busWrite; end
          W_BELL:    st.rdSel = RD_BELL;
          W_BELLSET: st.wrBellSet = busWrite;
          W_PROG:    begin st.rdSel = RD_AUX; st.auxIdx = 3'd0; st.wrAux[0] = busWrite; end
          W_SOFTP:   begin st.rdSel = RD_AUX; st.auxIdx = 3'd1; st.wrAux[1] = busWrite; end
          W_SOFTM:   begin st.rdSel = RD_AUX; st.auxIdx = 3'd2; st.wrAux[2] = busWrite; end
          W_DESCP:   begin st.rdSel = RD_AUX; st.auxIdx = 3'd3; st.wrAux[3] = busWrite; end
          W_DESCM:   begin st.rdSel = RD_AUX; st.auxIdx = 3'd4; st.wrAux[4] = busWrite; end
          default:   st.rdSel = RD_NONE;
        endcase
      end
    end
  end

  // R8: at most one channel window selected
  assert_chsel_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chSel));

  // R8: idle bus selects no channel
  assert_chsel_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (chSel == '0));

  // R10: at most one global write strobe per access
  assert_single_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({st.wrCtrl, st.wrPend, st.wrBellSet, st.wrAux}) <= 1);

endmodule

// File: rtl/dma_glob_datapath.sv
module dma_glob_datapath
  import dma_glob_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       st,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] chRdata,
  input  logic [NUM_CH-1:0] fetchAck,
  input  logic [NUM_CH-1:0] chDone,
  input  logic [NUM_CH-1:0] chHalt,
  input  logic [NUM_CH-1:0] chAddrErr,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] fetchReq,
  output logic              globalEn,
  output logic              fastMode,
  output logic [DATA_W-1:0] progMask,
  output logic              irq
);

  localparam int B_EN   = 0;
  localparam int B_AERR = 2;
  localparam int B_HALT = 3;
  localparam int B_FAST = DATA_W - 1;

  logic              enQ, fastQ, haltQ, addrErrQ;
  logic [NUM_CH-1:0] pendQ, bellQ;
  logic [DATA_W-1:0] auxQ [AUX_N];

  logic [NUM_CH-1:0] bellSetMask;
  logic [NUM_CH-1:0] pendKeep;

  assign bellSetMask = (st.wrBellSet && enQ) ? busWdata[NUM_CH-1:0] : '0;
  assign pendKeep    = st.wrPend ? (pendQ & busWdata[NUM_CH-1:0]) : pendQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      fastQ    <= 1'b0;
      haltQ    <= 1'b0;
      addrErrQ <= 1'b0;
      pendQ    <= '0;
      bellQ    <= '0;
      for (int i = 0; i < AUX_N; i++) auxQ[i] <= '0;
    end else begin
      if (st.wrCtrl) begin
        enQ   <= busWdata[B_EN];
        fastQ <= busWdata[B_FAST];
      end
      haltQ    <= (haltQ & ~(st.wrCtrl & ~busWdata[B_HALT])) | (|chHalt);
      addrErrQ <= (addrErrQ & ~(st.wrCtrl & ~busWdata[B_AERR])) | (|chAddrErr);
      pendQ    <= pendKeep | chDone;
      bellQ    <= (bellQ & ~fetchAck) | bellSetMask;
      for (int i = 0; i < AUX_N; i++)
        if (st.wrAux[i]) auxQ[i] <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (st.rdSel)
      RD_CTRL: begin
        busRdata[B_EN]   = enQ;
        busRdata[B_AERR] = addrErrQ;
        busRdata[B_HALT] = haltQ;
        busRdata[B_FAST] = fastQ;
      end
      RD_PEND: busRdata = DATA_W'(pendQ);
      RD_BELL: busRdata = DATA_W'(bellQ);
      RD_AUX:  if (st.auxIdx < 3'(AUX_N)) busRdata = auxQ[st.auxIdx];
      RD_CHAN: busRdata = chRdata;
      default: busRdata = '0;
    endcase
  end

  assign fetchReq = bellQ;
  assign globalEn = enQ;
  assign fastMode = fastQ;
  assign progMask = auxQ[0];
  assign irq      = enQ & (|pendQ);

  // R4: doorbell gains no bit while disabled
  assert_bell_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> ((bellQ & ~$past(bellQ)) == '0));

  // R5: acknowledged doorbell bits drop when no set write is present
  assert_bell_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrBellSet |=> ((bellQ & $past(fetchAck)) == '0));

  // R6: pending bits survive any cycle without a pending write
  assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrPend |=> ((bellQ | pendQ | ~pendQ) != '0) && ((pendQ & $past(pendQ)) == $past(pendQ)));

  // R3: halt summary is sticky without a control write
  assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && !st.wrCtrl) |=> haltQ);

  // R7: interrupt silent while disabled
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !irq);

endmodule

// File: rtl/dma_glob_regs.sv
module dma_glob_regs
  import dma_glob_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 32,
  parameter int NUM_CH       = 32,
  parameter int CH_WIN_BYTES = 32,
  parameter int GLOB_BASE    = 'h1000
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busSel,
  input  logic                            busWrite,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busWdata,
  output logic [DATA_W-1:0]               busRdata,
  output logic [NUM_CH-1:0]               chSel,
  output logic [$clog2(CH_WIN_BYTES)-3:0] chWordSel,
  input  logic [DATA_W-1:0]               chRdata,
  output logic [NUM_CH-1:0]               fetchReq,
  input  logic [NUM_CH-1:0]               fetchAck,
  input  logic [NUM_CH-1:0]               chDone,
  input  logic [NUM_CH-1:0]               chHalt,
  input  logic [NUM_CH-1:0]               chAddrErr,
  output logic                            globalEn,
  output logic                            fastMode,
  output logic [DATA_W-1:0]               progMask,
  output logic                            irq
);

  regStrobes_t st;

  dma_glob_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH),
    .CH_WIN_BYTES(CH_WIN_BYTES), .GLOB_BASE(GLOB_BASE)
  ) u_decode (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .st(st), .chSel(chSel), .chWordSel(chWordSel)
  );

  dma_glob_datapath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .st(st), .busWdata(busWdata),
    .chRdata(chRdata), .fetchAck(fetchAck), .chDone(chDone),
    .chHalt(chHalt), .chAddrErr(chAddrErr), .busRdata(busRdata),
    .fetchReq(fetchReq), .globalEn(globalEn), .fastMode(fastMode),
    .progMask(progMask), .irq(irq)
  );

endmodule

// File: tb/dma_glob_regs_tb.sv
module dma_glob_regs_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [12:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, chRdata = '0, progMask;
  logic [31:0] chSel, fetchReq;
  logic [31:0] fetchAck = '0, chDone = '0, chHalt = '0, chAddrErr = '0;
  logic [2:0]  chWordSel;
  logic        globalEn, fastMode, irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_glob_regs u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .chSel(chSel), .chWordSel(chWordSel), .chRdata(chRdata),
    .fetchReq(fetchReq), .fetchAck(fetchAck), .chDone(chDone),
    .chHalt(chHalt), .chAddrErr(chAddrErr), .globalEn(globalEn),
    .fastMode(fastMode), .progMask(progMask), .irq(irq)
  );

  // {isRead, addr, data, expected}
  localparam int NV = 22;
  localparam logic [77:0] VEC [NV] = '{
    {1'b1, 13'h1000, 32'h0,         32'h0},          // R1
    {1'b0, 13'h1000, 32'h8000_000D, 32'h0},
    {1'b1, 13'h1000, 32'h0,         32'h8000_0001},  // R2 R3
    {1'b0, 13'h101C, 32'hA5A5_1234, 32'h0},
    {1'b1, 13'h101C, 32'h0,         32'hA5A5_1234},  // R9
    {1'b0, 13'h1020, 32'h1111_0000, 32'h0},
    {1'b1, 13'h1020, 32'h0,         32'h1111_0000},  // R9
    {1'b0, 13'h1024, 32'h2222_0001, 32'h0},
    {1'b1, 13'h1024, 32'h0,         32'h2222_0001},  // R9
    {1'b0, 13'h1028, 32'h3333_0002, 32'h0},
    {1'b1, 13'h1028, 32'h0,         32'h3333_0002},  // R9
    {1'b0, 13'h102C, 32'h4444_0003, 32'h0},
    {1'b1, 13'h102C, 32'h0,         32'h4444_0003},  // R9
    {1'b0, 13'h100C, 32'h0000_0005, 32'h0},
    {1'b1, 13'h1008, 32'h0,         32'h0000_0005},  // R4
    {1'b0, 13'h1008, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 13'h100C, 32'h0,         32'h0},
    {1'b1, 13'h1008, 32'h0,         32'h0000_0005},  // R4
    {1'b1, 13'h100C, 32'h0,         32'h0},          // R4
    {1'b0, 13'h1014, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 13'h1014, 32'h0,         32'h0},          // R10
    {1'b1, 13'h0800, 32'h0,         32'h0}           // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d,
                    input logic [31:0] done_ = '0, input logic [31:0] ack = '0);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    chDone = done_; fetchAck = ack;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0; chDone = '0; fetchAck = '0;
  endtask

  task automatic rd(input string req, input logic [12:0] a, input logic [31:0] exp);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #5;
    chk(req, busRdata, exp);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic evt(input logic [31:0] d, input logic [31:0] h,
                     input logic [31:0] e, input logic [31:0] ack);
    chDone = d; chHalt = h; chAddrErr = e; fetchAck = ack;
    @(negedge clk);
    chDone = '0; chHalt = '0; chAddrErr = '0; fetchAck = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 fetchReq", fetchReq, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 progMask", progMask, 32'h0);
    chk("R1 chSel", chSel, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][77]) rd("vector", VEC[i][76:64], VEC[i][31:0]);
      else            wr(VEC[i][76:64], VEC[i][63:32]);
    end

    chk("R2 globalEn", {31'b0, globalEn}, 32'h1);
    chk("R2 fastMode", {31'b0, fastMode}, 32'h1);
    chk("R9 progMask", progMask, 32'hA5A5_1234);
    chk("R4 fetchReq", fetchReq, 32'h5);

    // R5: acknowledge clears, collision keeps the bit
    evt('0, '0, '0, 32'h1);
    chk("R5 ack clears", fetchReq, 32'h4);
    wr(13'h100C, 32'h4, '0, 32'h4);
    chk("R5 set beats ack", fetchReq, 32'h4);

    // R8: channel window routing
    chRdata = 32'hDEAD_BEEF;
    busSel = 1'b1; busWrite = 1'b0; busAddr = 13'h03A8;
    #5;
    chk("R8 chSel", chSel, 32'h2000_0000);
    chk("R8 chWordSel", {29'b0, chWordSel}, 32'h2);
    chk("R8 rdata", busRdata, 32'hDEAD_BEEF);
    busAddr = 13'h0400;
    #1;
    chk("R8 outside window chSel", chSel, 32'h0);
    chk("R10 gap read", busRdata, 32'h0);
    busSel = 1'b0; busAddr = 13'h0020;
    #1;
    chk("R8 idle chSel", chSel, 32'h0);
    @(negedge clk);

    // R6 R7: pending and interrupt
    evt(32'h8000_0008, '0, '0, '0);
    rd("R6 set", 13'h1004, 32'h8000_0008);
    chk("R7 irq on", {31'b0, irq}, 32'h1);
    wr(13'h1004, 32'h8000_0000);
    rd("R6 clear by zero", 13'h1004, 32'h8000_0000);
    wr(13'h1004, 32'h0, 32'h20);
    rd("R6 done beats clear", 13'h1004, 32'h20);
    wr(13'h1000, 32'h8000_0000);
    chk("R7 irq gated", {31'b0, irq}, 32'h0);
    rd("R2 ctrl fast only", 13'h1000, 32'h8000_0000);

    // R4: doorbell ignored while disabled
    wr(13'h100C, 32'h100);
    chk("R4 disabled ring", fetchReq, 32'h4);
    wr(13'h1000, 32'h1);
    chk("R7 irq back", {31'b0, irq}, 32'h1);

    // R3: summaries
    evt('0, 32'h80, '0, '0);
    rd("R3 halt set", 13'h1000, 32'h9);
    evt('0, '0, 32'h2, '0);
    rd("R3 addr err set", 13'h1000, 32'hD);
    wr(13'h1000, 32'h5);
    rd("R3 halt cleared only", 13'h1000, 32'h5);
    wr(13'h1000, 32'h1);
    rd("R3 addr err cleared", 13'h1000, 32'h1);

    // R1: reset again
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 fetchReq after reset", fetchReq, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd("R1 ctrl after reset", 13'h1000, 32'h0);
    rd("R1 pend after reset", 13'h1004, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule